// File: doc/BRIEF.md
# Counter Array Timebase

This block is the shared 16-bit time base for a group of five compare/capture units. It holds one free-running up-counter. A two-bit source selector decides what advances it. The choices are two internal prescaled enables taken from the block clock (one tick every six cycles, or one tick every two cycles), a one-cycle overflow pulse from a neighbouring timer, or rising edges seen on an external count pin. The count goes straight out to the compare/capture units.

Counting only happens while a run bit is set. Software may load the count at any time through a write strobe. When the counter wraps, a sticky overflow flag is set, and software clears it with a clear strobe. The overflow flag and the five unit flags are each masked by their own enable bit. The masked flags are then gated by a global enable into a single interrupt request.

Everything runs on one clock, and no derived clock is created. The external pin passes through a two-flop synchronizer before edge detection. The block also reports when it is claiming that pin, so the pin can serve as plain I/O otherwise. There is no streaming data path here, so every pin is a plain level or strobe with no handshake.

Top module: `ctr_timebase`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `count` is 0x0000, and `ovf_flag` and `irq_req` are 0.
- R2: With `src_sel` = 2'b00 and `run_en` = 1, the count advances by exactly one per six clock cycles, so any window of 6·m consecutive cycles adds exactly m.
- R3: With `src_sel` = 2'b01 and `run_en` = 1, the count advances by exactly one per two clock cycles, so any window of 2·m consecutive cycles adds exactly m.
- R4: With `src_sel` = 2'b10 and `run_en` = 1, the count advances by one in each cycle in which `tmr_ovf_pulse` is high, and holds in each cycle in which it is low.
- R5: With `src_sel` = 2'b11 and `run_en` = 1, the count advances once per low-to-high transition of `ext_pin`, after a two-flop synchronizer and edge detector. A level held high, and a falling edge, add nothing.
- R6: With `run_en` = 0 and no write, `count` holds its value whatever the selected source does.
- R7: When `cnt_wr_en` is high, `count` takes `cnt_wr_data` on the next cycle. This holds whether the counter is running or stopped, and the write wins over a tick in the same cycle.
- R8: A tick taken at count 0xFFFF wraps the count to 0x0000 and sets `ovf_flag` on the same edge. The flag stays set until a cycle with `ovf_clr` high clears it. A wrap in the same cycle as `ovf_clr` leaves the flag set.
- R9: `irq_req` = `glb_irq_en` AND ((`ovf_flag` AND `ovf_irq_en`) OR any bit of (`mod_flags` AND `mod_irq_en`)). The request is combinational, with bit i of the enable mask matching bit i of the flags.
- R10: `ext_in_use` is 1 exactly when `src_sel` = 2'b11. Toggling `ext_pin` under any other source leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run control; counting only while high |
| src_sel | input | 2 | Count source: 00 div-6, 01 div-2, 10 timer overflow, 11 external pin |
| tmr_ovf_pulse | input | 1 | One-cycle overflow pulse from the neighbouring timer |
| ext_pin | input | 1 | Asynchronous external count input |
| cnt_wr_en | input | 1 | Count load strobe |
| cnt_wr_data | input | 16 | Value loaded by the strobe |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| mod_flags | input | 5 | Event flags of the five compare/capture units |
| mod_irq_en | input | 5 | Per-unit interrupt enables |
| ovf_irq_en | input | 1 | Interrupt enable for the overflow flag |
| glb_irq_en | input | 1 | Global interrupt enable |
| count | output | 16 | Current time-base value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | Shared interrupt request |
| ext_in_use | output | 1 | High while the external pin is claimed as count source |

## Verification
Several properties are checked by assertions on every cycle:
- the count holding while stopped;
- a load landing on the next cycle;
- the wrap setting the flag;
- the flag staying sticky with a wrap winning over a clear;
- the single-cycle shape of the prescaler ticks and the detected pin edges;
- the masked overflow forcing the request.

The exact rates of the two prescaled sources, the one-count-per-edge behaviour of the external pin, and the full interrupt mask truth table only show in the bench's sweeps. Those sweeps cover windows of several lengths, all 256 eight-cycle timer-pulse patterns, pulse trains of one to eight edges, and every combination of unit flags and enables.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_FAST = 2'b01,
    SRC_TMR_OVF  = 2'b10,
    SRC_EXT_PIN  = 2'b11
  } src_sel_e;

  localparam int unsigned TB_CNT_W       = 16;
  localparam int unsigned TB_N_MOD       = 5;
  localparam int unsigned TB_DIV_SLOW    = 6;
  localparam int unsigned TB_DIV_FAST    = 2;
  localparam int unsigned TB_SYNC_STAGES = 2;

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  generate
    if (DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
      assign tick = (phase_q == LAST);

      // R2/R3: a prescaler tick never lasts two cycles
      a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pass
      always_ff @(posedge clk) phase_q <= '0;
      assign tick = rst_n | phase_q[0];
    end
  endgenerate
endmodule

// File: rtl/tbase_edge_sync.sv
module tbase_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R5: one detected edge produces exactly one single-cycle event
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic wrap;
  assign wrap = adv && !wr_en && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_en) begin
      count <= wr_data;
    end else if (adv) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (wrap) begin
      ovf_flag <= 1'b1;
    end else if (ovf_clr) begin
      ovf_flag <= 1'b0;
    end
  end

  // R7: a load lands on the next cycle
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));
  // R8: wrap from all-ones gives zero and the flag
  a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && count == CNT_MAX) |=> (count == '0) && ovf_flag);
  // R8: flag is sticky without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R6: no tick and no load keeps the count
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_en) |=> $stable(count));
endmodule

// File: rtl/tbase_irq.sv
module tbase_irq #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] flag_en,
  input  logic         ovf_flag,
  input  logic         ovf_en,
  input  logic         glb_en,
  output logic         irq
);
  logic [N:0] masked;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_mask
      assign masked[gi] = flags[gi] & flag_en[gi];
    end
  endgenerate
  assign masked[N] = ovf_flag & ovf_en;

  assign irq = glb_en & (|masked);
endmodule

// File: rtl/ctr_timebase.sv
module ctr_timebase
  import tbase_pkg::*;
#(
  parameter int unsigned CNT_W       = TB_CNT_W,
  parameter int unsigned N_MOD       = TB_N_MOD,
  parameter int unsigned DIV_SLOW    = TB_DIV_SLOW,
  parameter int unsigned DIV_FAST    = TB_DIV_FAST,
  parameter int unsigned SYNC_STAGES = TB_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       src_sel,
  input  logic             tmr_ovf_pulse,
  input  logic             ext_pin,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             ovf_clr,
  input  logic [N_MOD-1:0] mod_flags,
  input  logic [N_MOD-1:0] mod_irq_en,
  input  logic             ovf_irq_en,
  input  logic             glb_irq_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq_req,
  output logic             ext_in_use
);
  src_sel_e sel;
  logic     tick_slow, tick_fast, ext_rise, src_tick, adv;

  assign sel = src_sel_e'(src_sel);

  tbase_prescale #(.DIV(DIV_SLOW)) u_pre_slow (
    .clk(clk), .rst_n(rst_n), .tick(tick_slow));

  tbase_prescale #(.DIV(DIV_FAST)) u_pre_fast (
    .clk(clk), .rst_n(rst_n), .tick(tick_fast));

  tbase_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise));

  always_comb begin
    unique case (sel)
      SRC_DIV_SLOW: src_tick = tick_slow;
      SRC_DIV_FAST: src_tick = tick_fast;
      SRC_TMR_OVF:  src_tick = tmr_ovf_pulse;
      SRC_EXT_PIN:  src_tick = ext_rise;
      default:      src_tick = 1'b0;
    endcase
  end

  assign adv        = run_en & src_tick;
  assign ext_in_use = (sel == SRC_EXT_PIN);

  tbase_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .wr_en(cnt_wr_en),
    .wr_data(cnt_wr_data), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag));

  tbase_irq #(.N(N_MOD)) u_irq (
    .flags(mod_flags), .flag_en(mod_irq_en), .ovf_flag(ovf_flag),
    .ovf_en(ovf_irq_en), .glb_en(glb_irq_en), .irq(irq_req));

  // R6: stopped and not loaded means the count does not move
  a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr_en) |=> $stable(count));
  // R4: timer source, running, pulse high, no load: count steps by one
  a_r4_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sel == SRC_TMR_OVF && tmr_ovf_pulse && !cnt_wr_en)
      |=> count == $past(count) + 1'b1);
  // R9: masked overflow with global enable raises the request
  a_r9_ovf_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_irq_en && ovf_irq_en && ovf_flag) |-> irq_req);
  // R9: without global enable nothing requests
  a_r9_glb_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_irq_en) |-> !irq_req);
  // R1: the first cycle after reset starts from a cleared state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (count == '0) && !ovf_flag);
endmodule

// File: tb/tb_ctr_timebase.sv
module tb_ctr_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic        tmr_ovf_pulse = 1'b0;
  logic        ext_pin = 1'b0;
  logic        cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0;
  logic        ovf_clr = 1'b0;
  logic [4:0]  mod_flags = '0;
  logic [4:0]  mod_irq_en = '0;
  logic        ovf_irq_en = 1'b0;
  logic        glb_irq_en = 1'b0;
  logic [15:0] count;
  logic        ovf_flag, irq_req, ext_in_use;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ctr_timebase dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .tmr_ovf_pulse(tmr_ovf_pulse), .ext_pin(ext_pin),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .ovf_clr(ovf_clr),
    .mod_flags(mod_flags), .mod_irq_en(mod_irq_en), .ovf_irq_en(ovf_irq_en),
    .glb_irq_en(glb_irq_en), .count(count), .ovf_flag(ovf_flag),
    .irq_req(irq_req), .ext_in_use(ext_in_use));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v);
    cnt_wr_en = 1'b1; cnt_wr_data = v;
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R1 count in reset", count, 0);
    chk("R1 flag in reset", ovf_flag, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 count after reset", count, 0);
    chk("R1 irq after reset", irq_req, 0);

    // R2: div-6 windows
    run_en = 1'b1; src_sel = 2'b00;
    for (int m = 1; m <= 10; m++) begin
      load(16'h0000);
      cyc(6 * m);
      chk("R2 div6 window", count, m);
    end

    // R3: div-2 windows
    src_sel = 2'b01;
    for (int m = 1; m <= 12; m++) begin
      load(16'h0000);
      cyc(2 * m);
      chk("R3 div2 window", count, m);
    end

    // R6: stopped with a live source
    run_en = 1'b0;
    load(16'h1234);
    cyc(25);
    chk("R6 hold while stopped", count, 16'h1234);
    run_en = 1'b1;

    // R4: every 8-cycle timer pulse pattern
    src_sel = 2'b10;
    for (int p = 0; p < 256; p++) begin
      load(16'h0000);
      for (int i = 0; i < 8; i++) begin
        tmr_ovf_pulse = p[i];
        @(negedge clk);
      end
      tmr_ovf_pulse = 1'b0;
      chk("R4 timer pulses", count, $countones(p[7:0]));
    end

    // R10: pin ignored under timer source
    chk("R10 pin not claimed", ext_in_use, 0);
    load(16'h0040);
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1'b1; cyc(3); ext_pin = 1'b0; cyc(3);
    end
    cyc(4);
    chk("R10 pin ignored", count, 16'h0040);

    // R5: pulse trains on the external pin
    src_sel = 2'b11;
    cyc(1);
    chk("R10 pin claimed", ext_in_use, 1);
    for (int n = 1; n <= 8; n++) begin
      load(16'h0000);
      for (int i = 0; i < n; i++) begin
        ext_pin = 1'b1; cyc(3); ext_pin = 1'b0; cyc(3);
      end
      cyc(4);
      chk("R5 pin edges", count, n);
    end
    load(16'h0000);
    ext_pin = 1'b1; cyc(20);
    chk("R5 held level counts once", count, 1);
    ext_pin = 1'b0; cyc(6);
    chk("R5 falling edge adds nothing", count, 1);

    // R7: write wins over a tick, and works while running
    src_sel = 2'b10; tmr_ovf_pulse = 1'b1;
    load(16'hABCD);
    chk("R7 load over tick", count, 16'hABCD);
    cyc(1);
    chk("R7 counting resumes", count, 16'hABCE);
    tmr_ovf_pulse = 1'b0;

    // R8: wrap, sticky flag, clear, wrap beats clear
    load(16'hFFFE);
    tmr_ovf_pulse = 1'b1; cyc(1); tmr_ovf_pulse = 1'b0;
    chk("R8 no flag before wrap", ovf_flag, 0);
    tmr_ovf_pulse = 1'b1; cyc(1); tmr_ovf_pulse = 1'b0;
    chk("R8 wrap count", count, 0);
    chk("R8 wrap flag", ovf_flag, 1);
    cyc(10);
    chk("R8 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R8 flag cleared", ovf_flag, 0);
    load(16'hFFFF);
    tmr_ovf_pulse = 1'b1; ovf_clr = 1'b1; cyc(1);
    tmr_ovf_pulse = 1'b0; ovf_clr = 1'b0;
    chk("R8 wrap beats clear", ovf_flag, 1);

    // R9: full mask sweep with the flag set, then cleared
    for (int f = 1; f >= 0; f--) begin
      if (f == 0) begin
        ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
      end
      for (int v = 0; v < 4096; v++) begin
        @(negedge clk);
        mod_flags  = v[4:0];
        mod_irq_en = v[9:5];
        ovf_irq_en = v[10];
        glb_irq_en = v[11];
        #1;
        chk("R9 irq combine", irq_req,
            int'(v[11] && ((|(v[4:0] & v[9:5])) || (v[10] && (f == 1)))));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule